// File: doc/BRIEF.md
# Sixteen-bit two-level carry-lookahead adder

This block adds two 16-bit unsigned operands and a carry input in a single combinational pass and returns a 16-bit sum and a carry output. The operands are split into four 4-bit slices. Each slice forms per-bit generate (both bits set) and propagate (bits differ) terms and derives every internal carry as a flat sum of products. Each slice also reduces its terms to one group generate and one group propagate.

A second lookahead unit has the same form as the one inside a slice. It takes the four group pairs and the carry input, and it produces the carry into each upper slice and the final carry output. No carry passes from one slice to the next through a chain. The block also brings out the generate and propagate for the full 16-bit group, so a third level can be placed above several instances.

The block has no clock and no state, so there is no stream interface. An operand change appears at the outputs in the same cycle, after the combinational delay.

Top module: `cla_adder_top`

## Requirements
- R1: `sum_o` equals the low 16 bits of `op_a + op_b + carry_in`.
- R2: `carry_out` equals bit 16 of `op_a + op_b + carry_in`.
- R3: `grp_prop_o` is 1 exactly when `op_a ^ op_b` is all ones.
- R4: `grp_gen_o` is 1 exactly when `op_a + op_b`, with no carry input, reaches 65536 or more.
- R5: `carry_out` equals `grp_gen_o | (grp_prop_o & carry_in)` for every input.
- R6: When every bit position propagates, the sum is 0x0000 with a carry output of 1 if `carry_in` is 1, and 0xFFFF with a carry output of 0 if `carry_in` is 0.
- R7: A carry generated in the lowest slice crosses every slice boundary. For example, 0x0001 + 0xFFFF gives sum 0x0000 and carry output 1. The carry that the second level delivers to each slice equals the carry out of the slice below it.
- R8: All outputs are purely combinational. With both operands and `carry_in` at zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 1 | Generate of the whole 16-bit group |
| grp_prop_o | output | 1 | Propagate of the whole 16-bit group |

## Verification
The block holds no state, so a wrong term in a lookahead product shows at the ports for the same operand pair that triggers it, with no delay. A missing propagate factor, or a wrong slice carry from the second level, only shows when a carry has to cross that position. For that reason the long all-propagate chains and the generate-at-bit-0 cases are driven on purpose, together with random operands. A group term that is wrong affects `carry_out` and the group outputs together, so R5 ties them to each other.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_DATA_W  = 16;
  localparam int unsigned CLA_SLICE_W = 4;
endpackage

// File: rtl/cla_pg_bits.sv
module cla_pg_bits #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:0]   carry_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  assign carry_o[0] = cin_i;

  for (genvar j = 1; j <= N; j++) begin : g_carry
    always_comb begin
      logic acc;
      logic term;
      acc = cin_i;
      for (int m = 0; m < j; m++) acc = acc & prop_i[m];
      for (int k = 0; k < j; k++) begin
        term = gen_i[k];
        for (int m = k + 1; m < j; m++) term = term & prop_i[m];
        acc = acc | term;
      end
      carry_o[j] = acc;
    end

    // R7
    always_comb begin
      carry_step_chk: assert (carry_o[j] == (gen_i[j-1] | (prop_i[j-1] & carry_o[j-1])))
        else $error("lookahead carry %0d disagrees with one-step recurrence", j);
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int k = 0; k < N; k++) begin
      term = gen_i[k];
      for (int m = k + 1; m < N; m++) term = term & prop_i[m];
      acc = acc | term;
    end
    grp_gen_o = acc;
  end

  assign grp_prop_o = &prop_i;

  // R5
  always_comb begin
    group_carry_chk: assert (carry_o[N] == (grp_gen_o | (grp_prop_o & cin_i)))
      else $error("group carry out disagrees with group terms");
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  cla_pg_bits #(.W(W)) pg_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .gen_o (gen),
    .prop_o(prop)
  );

  cla_lookahead #(.N(W)) la_i (
    .gen_i     (gen),
    .prop_i    (prop),
    .cin_i     (cin_i),
    .carry_o   (carry),
    .grp_gen_o (grp_gen_o),
    .grp_prop_o(grp_prop_o)
  );

  assign sum_o  = prop ^ carry[W-1:0];
  assign cout_o = carry[W];

  // R1
  always_comb begin
    slice_sum_chk: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("slice sum mismatch");
  end
endmodule

// File: rtl/cla_adder_top.sv
module cla_adder_top
  import cla_pkg::*;
#(
  parameter int unsigned DATA_W  = CLA_DATA_W,
  parameter int unsigned SLICE_W = CLA_SLICE_W
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_out,
  output logic              grp_gen_o,
  output logic              grp_prop_o
);
  localparam int unsigned NSLICE = DATA_W / SLICE_W;

  logic [NSLICE-1:0] s_gen;
  logic [NSLICE-1:0] s_prop;
  logic [NSLICE-1:0] s_cout;
  logic [NSLICE:0]   s_carry;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    cla_slice #(.W(SLICE_W)) slice_i (
      .a_i       (op_a[k*SLICE_W +: SLICE_W]),
      .b_i       (op_b[k*SLICE_W +: SLICE_W]),
      .cin_i     (s_carry[k]),
      .sum_o     (sum_o[k*SLICE_W +: SLICE_W]),
      .cout_o    (s_cout[k]),
      .grp_gen_o (s_gen[k]),
      .grp_prop_o(s_prop[k])
    );

    // R7
    always_comb begin
      slice_handoff_chk: assert (s_carry[k+1] == s_cout[k])
        else $error("second-level carry into slice %0d differs from slice below", k + 1);
    end
  end

  cla_lookahead #(.N(NSLICE)) upper_i (
    .gen_i     (s_gen),
    .prop_i    (s_prop),
    .cin_i     (carry_in),
    .carry_o   (s_carry),
    .grp_gen_o (grp_gen_o),
    .grp_prop_o(grp_prop_o)
  );

  assign carry_out = s_carry[NSLICE];

  // R1
  always_comb begin
    full_sum_chk: assert ({carry_out, sum_o} ==
                          ({1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in}))
      else $error("16-bit sum mismatch");
  end

  // R3
  always_comb begin
    all_prop_chk: assert (grp_prop_o == ((op_a ^ op_b) == {DATA_W{1'b1}}))
      else $error("group propagate mismatch");
  end
endmodule

// File: tb/cla_adder_top_tb_top.sv
module cla_adder_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum_o;
  logic        carry_out;
  logic        grp_gen_o;
  logic        grp_prop_o;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cla_adder_top dut_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_o     (sum_o),
    .carry_out (carry_out),
    .grp_gen_o (grp_gen_o),
    .grp_prop_o(grp_prop_o)
  );

  function automatic logic [16:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                          input logic c);
    return {1'b0, a} + {1'b0, b} + {16'd0, c};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h c=%b actual=%h expected=%h", req, op_a, op_b, carry_in, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [16:0] r;
    logic [16:0] r0;
    @(posedge clk);
    op_a = a; op_b = b; carry_in = c;
    @(negedge clk);
    r  = ref_add(a, b, c);
    r0 = ref_add(a, b, 1'b0);
    check("R1", {16'd0, sum_o}, {16'd0, r[15:0]});
    check("R2", {31'd0, carry_out}, {31'd0, r[16]});
    check("R3", {31'd0, grp_prop_o}, {31'd0, ((a ^ b) == 16'hFFFF)});
    check("R4", {31'd0, grp_gen_o}, {31'd0, r0[16]});
    check("R5", {31'd0, carry_out}, {31'd0, grp_gen_o | (grp_prop_o & c)});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: all-zero inputs give all-zero outputs
    check("R8", {13'd0, sum_o, carry_out, grp_gen_o, grp_prop_o}, 32'd0);
    // R6: full propagate chains
    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R6", {15'd0, carry_out, sum_o}, {15'd0, 1'b1, 16'h0000});
    apply(16'hFFFF, 16'h0000, 1'b0);
    check("R6", {15'd0, carry_out, sum_o}, {15'd0, 1'b0, 16'hFFFF});
    apply(16'hA5A5, 16'h5A5A, 1'b1);
    check("R6", {15'd0, carry_out, sum_o}, {15'd0, 1'b1, 16'h0000});
    // R7: generate at bit 0 crossing every slice boundary
    apply(16'h0001, 16'hFFFF, 1'b0);
    check("R7", {15'd0, carry_out, sum_o}, {15'd0, 1'b1, 16'h0000});
    apply(16'h0008, 16'h0FF8, 1'b0);
    check("R7", {15'd0, carry_out, sum_o}, {15'd0, 1'b0, 16'h1000});
    apply(16'h00F0, 16'h0010, 1'b0);
    check("R7", {15'd0, carry_out, sum_o}, {15'd0, 1'b0, 16'h0100});
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h8000, 16'h8000, 1'b0);
    // Carry entering each slice through a propagate run
    for (int s = 0; s < 4; s++) begin
      apply(16'hFFFF >> (4 * s), 16'h0000, 1'b1);
      apply(16'h0001 << (4 * s), (16'hFFFF << (4 * s)), 1'b0);
    end
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [15:0] b;
      a = 16'($urandom);
      b = 16'($urandom);
      if (i % 5 == 0) b = ~a ^ (16'h1 << ($urandom % 16));
      apply(a, b, 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule